// File: doc/BRIEF.md
# Coprocessor Bus Snooper

This block is the front end of a numeric coprocessor that sits beside a host processor on a shared bus. Bus fetches alone do not show when the host executes an instruction, so the block keeps its own copy of the host's prefetch queue. It fills that copy from the host's instruction fetches and drains it as the host's queue-status lines report bytes being taken. When an instruction that starts with an escape byte is executed, the block decodes the addressing byte that follows it. It passes the coprocessor opcode to an execute stub.

For a memory operand, the block takes the operand address from the host's own read cycle. It then moves the rest of the operand itself: it requests the bus, runs one transfer per clock once granted, and releases the bus. Read operands are delivered word by word on an operand port. For store operands the data the host read is thrown away; only the address is kept, and the whole operand is written by the block.

While in reset, the block samples the data bus to learn whether the host bus is 16 or 8 bits wide. That choice sets the queue depth, the number of bytes per fetch and the address step between transfers.

Top module: `cop_snoop`

## Requirements
- R1: During reset, `host_wide` takes the value of `bus_data[15]` in the last reset cycle. 1 means a 16-bit host and 0 means an 8-bit host. It does not change outside reset.
- R2: The queue mirror works as follows. A completed fetch appends `bus_data[7:0]`, then `bus_data[15:8]` on a 16-bit host; on an 8-bit host it appends only `bus_data[7:0]`. Queue-status codes are 00 idle, 01 first byte of an instruction taken, 10 flush, 11 later byte taken. Codes 01 and 11 remove the oldest byte; a take from an empty queue has no effect. A flush empties the queue, drops any fetch in the same cycle and abandons a decode waiting for its addressing byte. A fetch that would make the queue exceed 6 bytes (16-bit host) or 4 bytes (8-bit host) is dropped whole.
- R3: Only a byte taken with code 01 whose bits [7:3] are 11011 starts a coprocessor instruction. Any other first byte gives no `ex_valid`.
- R4: The next byte taken with code 11 after an escape byte is the addressing byte. One cycle after that take, `ex_valid` pulses for a single cycle with `ex_op` = {escape[2:0], addr_byte[5:3]}, `ex_mod` = addr_byte[7:6] and `ex_rm` = addr_byte[2:0].
- R5: Escape bits [2:1] give the operand length: 00 is 4 bytes, 01 is 2, 10 is 8 and 11 is 10. Addressing byte bit 4 set marks a store; clear marks a load. `ex_mod` = 11 means a register operand with no bus activity.
- R6: For a memory load, the first host read cycle after the decode supplies the base address. One cycle later, `opd_valid` pulses with that cycle's data. On an 8-bit host the data is the low byte, zero-extended.
- R7: After the host read, a load needs N extra words and a store needs N+1 transfers. N is length/2 − 1 on a 16-bit host and length − 1 on an 8-bit host. When any transfer is needed, `hreq` rises the cycle after the host read. The first transfer occurs the cycle after `hgnt` is sampled high. `hreq` falls the cycle after the last transfer.
- R8: Transfers run one per cycle with `cop_rd` or `cop_wr` high. `cop_idx` counts the words, starting at 1 for loads and 0 for stores. `cop_addr` = base + `cop_idx` × (2 on a 16-bit host, 1 on an 8-bit host). Each own read returns its data on `opd_valid`/`opd_data` one cycle later.
- R9: For a store, the data of the host read cycle is ignored and no `opd_valid` is produced.
- R10: Bytes taken while a memory operand is pending or moving start no decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 16 | Shared data bus |
| bus_addr | input | 20 | Address of the host's read cycle |
| fetch_done | input | 1 | Host instruction fetch completes this cycle |
| q_stat | input | 2 | Host queue status code |
| host_rd | input | 1 | Host data read cycle completes this cycle |
| hgnt | input | 1 | Bus grant to this block |
| host_wide | output | 1 | 1: 16-bit host, 0: 8-bit host |
| hreq | output | 1 | Bus request, held until the bus is released |
| cop_rd | output | 1 | Own read transfer this cycle |
| cop_wr | output | 1 | Own write transfer this cycle |
| cop_addr | output | 20 | Address of the own transfer |
| cop_idx | output | 4 | Word index of the own transfer |
| ex_valid | output | 1 | Decoded instruction strobe |
| ex_op | output | 6 | Coprocessor opcode |
| ex_mod | output | 2 | Addressing mode field |
| ex_rm | output | 3 | Register/memory field |
| opd_valid | output | 1 | Operand word strobe |
| opd_data | output | 16 | Operand word |

## Verification
The decode strobe is due one cycle after the addressing byte is taken. Each operand word is due one cycle after the read that carried it, whether the host or the block ran that read. The request rises one cycle after the host read, the first transfer comes one cycle after the grant is sampled, and the request falls one cycle after the last transfer. The bench changes inputs on the falling edge. Its reference model steps on the rising edge using the same sampled inputs, and its results are compared with the ports at the next falling edge, so every result is checked in exactly the cycle it is due. The stimulus covers both bus widths, queue overflow, flushes during a decode, delayed grants and operands of every length class.

// File: rtl/cop_snoop.sv
module cop_snoop #(
  parameter int AW   = 20,
  parameter int QD16 = 6,
  parameter int QD8  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   bus_data,
  input  logic [AW-1:0] bus_addr,
  input  logic          fetch_done,
  input  logic [1:0]    q_stat,
  input  logic          host_rd,
  input  logic          hgnt,
  output logic          host_wide,
  output logic          hreq,
  output logic          cop_rd,
  output logic          cop_wr,
  output logic [AW-1:0] cop_addr,
  output logic [3:0]    cop_idx,
  output logic          ex_valid,
  output logic [5:0]    ex_op,
  output logic [1:0]    ex_mod,
  output logic [2:0]    ex_rm,
  output logic          opd_valid,
  output logic [15:0]   opd_data
);
  localparam int QMAX = (QD16 > QD8) ? QD16 : QD8;
  localparam int CW   = $clog2(QMAX + 1);
  localparam logic [1:0] QS_FIRST = 2'b01, QS_FLUSH = 2'b10, QS_NEXT = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_MODRM, S_WRD, S_REQ, S_XFER} st_t;
  st_t st;

  logic [7:0]    q  [QMAX];
  logic [7:0]    qn [QMAX];
  logic [CW-1:0] qcnt;
  int            cn;
  logic          pop;
  logic [7:0]    popb;
  logic [2:0]    esc;
  logic [1:0]    lcode;
  logic          wr;
  logic [3:0]    k, last, nx, lenb;
  logic [AW-1:0] base;

  assign pop  = (q_stat == QS_FIRST || q_stat == QS_NEXT) && qcnt != '0;
  assign popb = q[0];

  always_comb
    case (lcode)
      2'd0:    lenb = 4'd4;
      2'd1:    lenb = 4'd2;
      2'd2:    lenb = 4'd8;
      default: lenb = 4'd10;
    endcase

  assign nx = host_wide ? (lenb >> 1) - 4'd1 : lenb - 4'd1;

  always_comb begin
    cn = int'(qcnt);
    for (int i = 0; i < QMAX; i++) qn[i] = q[i];
    if (pop) begin
      for (int i = 0; i < QMAX - 1; i++) qn[i] = q[i+1];
      cn = cn - 1;
    end
    if (q_stat == QS_FLUSH) begin
      cn = 0;
    end else if (fetch_done) begin
      if (host_wide && cn + 2 <= QD16) begin
        for (int i = 0; i < QMAX; i++) begin
          if (i == cn)     qn[i] = bus_data[7:0];
          if (i == cn + 1) qn[i] = bus_data[15:8];
        end
        cn = cn + 2;
      end else if (!host_wide && cn + 1 <= QD8) begin
        for (int i = 0; i < QMAX; i++)
          if (i == cn) qn[i] = bus_data[7:0];
        cn = cn + 1;
      end
    end
  end

  assign hreq     = st == S_REQ || st == S_XFER;
  assign cop_rd   = st == S_XFER && !wr;
  assign cop_wr   = st == S_XFER && wr;
  assign cop_idx  = k;
  assign cop_addr = base + (host_wide ? AW'({k, 1'b0}) : AW'(k));

  always_ff @(posedge clk)
    for (int i = 0; i < QMAX; i++) q[i] <= qn[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_wide <= bus_data[15];
      qcnt      <= '0;
      st        <= S_IDLE;
      ex_valid  <= 1'b0;
      ex_op     <= '0;
      ex_mod    <= '0;
      ex_rm     <= '0;
      opd_valid <= 1'b0;
      opd_data  <= '0;
      esc       <= '0;
      lcode     <= '0;
      wr        <= 1'b0;
      k         <= '0;
      last      <= '0;
      base      <= '0;
    end else begin
      qcnt      <= CW'(cn);
      ex_valid  <= 1'b0;
      opd_valid <= 1'b0;
      case (st)
        S_IDLE, S_MODRM: begin
          if (pop && q_stat == QS_FIRST) begin
            esc <= popb[2:0];
            st  <= (popb[7:3] == 5'b11011) ? S_MODRM : S_IDLE;
          end else if (st == S_MODRM && pop && q_stat == QS_NEXT) begin
            ex_valid <= 1'b1;
            ex_op    <= {esc, popb[5:3]};
            ex_mod   <= popb[7:6];
            ex_rm    <= popb[2:0];
            wr       <= popb[4];
            lcode    <= esc[2:1];
            st       <= (popb[7:6] != 2'b11) ? S_WRD : S_IDLE;
          end else if (st == S_MODRM && q_stat == QS_FLUSH) begin
            st <= S_IDLE;
          end
        end
        S_WRD: if (host_rd) begin
          base <= bus_addr;
          if (!wr) begin
            opd_valid <= 1'b1;
            opd_data  <= host_wide ? bus_data : {8'h00, bus_data[7:0]};
          end
          last <= nx;
          k    <= wr ? 4'd0 : 4'd1;
          st   <= (wr || nx != 4'd0) ? S_REQ : S_IDLE;
        end
        S_REQ: if (hgnt) st <= S_XFER;
        S_XFER: begin
          if (!wr) begin
            opd_valid <= 1'b1;
            opd_data  <= host_wide ? bus_data : {8'h00, bus_data[7:0]};
          end
          if (k == last) st <= S_IDLE;
          else           k  <= k + 4'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cop_snoop_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hgnt,
  input logic          hreq,
  input logic          cop_rd,
  input logic          cop_wr,
  input logic [AW-1:0] cop_addr,
  input logic          host_wide,
  input logic          ex_valid,
  input logic          opd_valid
);
  AST_XFER_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_rd || cop_wr) |-> hreq); // R7
  AST_START_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cop_rd || cop_wr) |-> $past(hgnt)); // R7
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cop_rd && cop_wr)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cop_rd || cop_wr) && $past(cop_rd || cop_wr)) |->
      cop_addr == $past(cop_addr) + (host_wide ? AW'(2) : AW'(1))); // R8
  AST_RD_RETURNS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cop_rd) |-> opd_valid); // R8
  AST_WR_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cop_wr) |-> !opd_valid); // R9
  AST_EX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> !ex_valid); // R4
endmodule

bind cop_snoop cop_snoop_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hgnt(hgnt), .hreq(hreq), .cop_rd(cop_rd),
  .cop_wr(cop_wr), .cop_addr(cop_addr), .host_wide(host_wide),
  .ex_valid(ex_valid), .opd_valid(opd_valid)
);

// File: tb/cop_snoop_bench.sv
`timescale 1ns/1ps
module cop_snoop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] drv_data = 16'h8000;
  logic [19:0] bus_addr = '0;
  logic        fetch_done = 1'b0;
  logic [1:0]  q_stat = 2'b00;
  logic        host_rd = 1'b0;
  logic        hgnt = 1'b0;
  logic [15:0] bus_data;
  logic        host_wide, hreq, cop_rd, cop_wr, ex_valid, opd_valid;
  logic [19:0] cop_addr;
  logic [3:0]  cop_idx;
  logic [5:0]  ex_op;
  logic [1:0]  ex_mod;
  logic [2:0]  ex_rm;
  logic [15:0] opd_data;

  always #2 clk = ~clk;

  assign bus_data = cop_rd ? (cop_addr[15:0] ^ 16'h5A5A) : drv_data;

  cop_snoop u_cop_snoop (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .fetch_done(fetch_done), .q_stat(q_stat), .host_rd(host_rd), .hgnt(hgnt),
    .host_wide(host_wide), .hreq(hreq), .cop_rd(cop_rd), .cop_wr(cop_wr),
    .cop_addr(cop_addr), .cop_idx(cop_idx), .ex_valid(ex_valid), .ex_op(ex_op),
    .ex_mod(ex_mod), .ex_rm(ex_rm), .opd_valid(opd_valid), .opd_data(opd_data)
  );

  int tests = 0, fails = 0;
  bit done = 0, armed = 0;

  logic [7:0]  mq[$];
  int          mst, mk, mlast, mlen, s0, n;
  logic        mwide, mwr, popped;
  logic [2:0]  mesc;
  logic [7:0]  b;
  logic [19:0] mbase;
  logic        e_exv, e_opv;
  logic [5:0]  e_op;
  logic [1:0]  e_mod;
  logic [2:0]  e_rm;
  logic [15:0] e_opd;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (!rst_n) begin
      mwide = bus_data[15];
      mq.delete();
      mst = 0; mk = 0; mlast = 0; mlen = 4; mwr = 0; mesc = 0; mbase = 0;
      e_exv = 0; e_opv = 0; e_op = 0; e_mod = 0; e_rm = 0; e_opd = 0;
    end else begin
      s0 = mst; e_exv = 0; e_opv = 0; popped = 0; b = 8'h00;
      if ((q_stat == 2'b01 || q_stat == 2'b11) && mq.size() > 0) begin
        b = mq.pop_front(); popped = 1;
      end
      if (q_stat == 2'b10) mq.delete();
      else if (fetch_done) begin
        if (mwide && mq.size() + 2 <= 6) begin
          mq.push_back(bus_data[7:0]); mq.push_back(bus_data[15:8]);
        end else if (!mwide && mq.size() + 1 <= 4) mq.push_back(bus_data[7:0]);
      end
      if (s0 <= 1) begin
        if (popped && q_stat == 2'b01) begin
          mesc = b[2:0];
          mst = (b[7:3] == 5'b11011) ? 1 : 0;
        end else if (s0 == 1 && popped && q_stat == 2'b11) begin
          e_exv = 1; e_op = {mesc, b[5:3]}; e_mod = b[7:6]; e_rm = b[2:0];
          mwr = b[4];
          case (mesc[2:1]) 2'd0: mlen = 4; 2'd1: mlen = 2; 2'd2: mlen = 8; default: mlen = 10; endcase
          mst = (b[7:6] != 2'b11) ? 2 : 0;
        end else if (s0 == 1 && q_stat == 2'b10) mst = 0;
      end else if (s0 == 2) begin
        if (host_rd) begin
          mbase = bus_addr;
          if (!mwr) begin e_opv = 1; e_opd = mwide ? bus_data : {8'h00, bus_data[7:0]}; end
          n = mwide ? mlen / 2 - 1 : mlen - 1;
          mlast = n; mk = mwr ? 0 : 1;
          mst = (mwr || n > 0) ? 3 : 0;
        end
      end else if (s0 == 3) begin
        if (hgnt) mst = 4;
      end else begin
        if (!mwr) begin e_opv = 1; e_opd = mwide ? bus_data : {8'h00, bus_data[7:0]}; end
        if (mk == mlast) mst = 0; else mk = mk + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed && !done) begin
    logic [19:0] ea;
    logic        xf;
    xf = (mst == 4);
    ea = mbase + 20'(mwide ? 2 * mk : mk);
    chk("R1 host_wide", 32'(host_wide), 32'(mwide));
    chk("R3 R10 ex_valid", 32'(ex_valid), 32'(e_exv));
    if (e_exv) begin
      chk("R4 ex_op", 32'(ex_op), 32'(e_op));
      chk("R4 ex_mod", 32'(ex_mod), 32'(e_mod));
      chk("R4 ex_rm", 32'(ex_rm), 32'(e_rm));
    end
    chk("R5 R7 hreq", 32'(hreq), 32'(mst == 3 || mst == 4));
    chk("R8 cop_rd", 32'(cop_rd), 32'(xf && !mwr));
    chk("R8 cop_wr", 32'(cop_wr), 32'(xf && mwr));
    if (xf) begin
      chk("R8 cop_addr", 32'(cop_addr), 32'(ea));
      chk("R8 cop_idx", 32'(cop_idx), 32'(mk));
    end
    chk("R6 R9 opd_valid", 32'(opd_valid), 32'(e_opv));
    if (e_opv) chk("R6 R8 opd_data", 32'(opd_data), 32'(e_opd));
  end

  task automatic tick(input logic fd, input logic [15:0] d, input logic [1:0] qv,
                      input logic hr, input logic [19:0] a, input logic g);
    @(negedge clk);
    fetch_done = fd; drv_data = d; q_stat = qv; host_rd = hr; bus_addr = a; hgnt = g;
  endtask
  task automatic fetchw(input logic [15:0] w); tick(1, w, 2'b00, 0, 0, 0); endtask
  task automatic popf(); tick(0, 0, 2'b01, 0, 0, 0); endtask
  task automatic popn(); tick(0, 0, 2'b11, 0, 0, 0); endtask
  task automatic flush(); tick(0, 0, 2'b10, 0, 0, 0); endtask
  task automatic hrd(input logic [19:0] a, input logic [15:0] d); tick(0, d, 2'b00, 1, a, 0); endtask
  task automatic idle(input int n, input logic g);
    for (int i = 0; i < n; i++) tick(0, 0, 2'b00, 0, 0, g);
  endtask
  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst_n = 0; fetch_done = 0; q_stat = 0; host_rd = 0; hgnt = 0;
    drv_data = wide ? 16'h8000 : 16'h0000;
    idle(0, 0);
    repeat (3) @(negedge clk);
    drv_data = 16'h0000;
    rst_n = 1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    drv_data = 16'h0000; rst_n = 1;                // R1: 16-bit host
    // R3: non-escape first byte, then register-mode escape (R4 R5)
    fetchw(16'hD990); fetchw(16'h00C1);
    popf(); popf(); popn(); idle(2, 0);
    flush(); idle(1, 0);
    // R2: overflow of the 6-byte queue, take from empty queue
    fetchw(16'hD990); fetchw(16'h90C8); fetchw(16'hC3D9); fetchw(16'h2211);
    popf(); popf(); popn(); popf(); popf(); popn(); popf(); idle(2, 0);
    // R2: flush abandons a pending decode, later byte then ignored
    fetchw(16'hC0D8); popf(); flush(); fetchw(16'hC090); popf(); popn(); idle(2, 0);
    // R6 R7 R8: 10-byte load, delayed grant; R10: byte taken while pending
    fetchw(16'h06DF); fetchw(16'h3412); fetchw(16'h00D9);
    popf(); popn(); popn(); popn(); popf(); idle(1, 0);
    hrd(20'h01000, 16'hBEEF); idle(3, 0); idle(7, 1); idle(2, 0);
    flush();
    // R9: 8-byte store, immediate grant
    fetchw(16'h1EDD); fetchw(16'h0020);
    popf(); popn(); popn(); popn();
    hrd(20'h02000, 16'hFFFF); idle(8, 1); idle(2, 0);
    // R7: 4-byte load needs one extra word; 2-byte load needs none
    fetchw(16'h07D9); popf(); popn(); hrd(20'h0FFFE, 16'h1234); idle(4, 1); idle(1, 0);
    fetchw(16'h45DB); fetchw(16'h0010);
    popf(); popn(); popn(); hrd(20'h04000, 16'h5678); idle(3, 1);
    // R1: 8-bit host
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) tick(1, 16'hAA00 | 16'(8'hD9 - i), 2'b00, 0, 0, 0);
    for (int i = 0; i < 5; i++) popf();
    idle(1, 0);
    tick(1, 16'h11D9, 2'b00, 0, 0, 0); tick(1, 16'h2207, 2'b00, 0, 0, 0);
    popf(); popn(); hrd(20'h03000, 16'hABCD); idle(2, 0); idle(6, 1); idle(1, 0);
    tick(1, 16'h00DB, 2'b00, 0, 0, 0); tick(1, 16'h0017, 2'b00, 0, 0, 0);
    popf(); popn(); hrd(20'h05000, 16'h9999); idle(5, 1); idle(2, 0);
    // R1: back to a 16-bit host
    do_reset(1'b1);
    idle(3, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule